// File: doc/BRIEF.md
# Bridge Data Parity Error Reporter

This block collects data parity error events seen by a two-port bus bridge and turns them into sticky status flags plus a pulsed, active-low system error output. Each cycle a single event strobe may arrive, tagged with four attributes: the kind of transaction (read or posted write), the direction of travel (downstream or upstream), the bus on which the error was seen (primary or secondary), and whether the bad parity was already present on the initiating bus and was carried across.

Four configuration enables gate the reporting: a system-error enable, a parity-response enable for each of the two interfaces, and a disable that suppresses system error for posted-write parity events. The system error pulse exists for posted writes that the target reported as bad. The initiator finished such a write cleanly, so it has no other way to learn of the failure. Software clears the status flags by writing ones to a simple clear port for each status word.

All outputs are registered. An event presented on the cycle before a clock edge shows in the status words and on the system error pin right after that edge.

Top module: `bridge_perr_report`

## Requirements
- R1: After reset, both status words read zero and `serr_n_o` is high.
- R2: Any event with `evt_sec_i`=0 (primary bus) sets primary status bit 31, and any event with `evt_sec_i`=1 sets secondary status bit 31. This happens for every transaction kind and direction, whatever the configuration.
- R3: A posted write (`evt_pw_i`=1) that is downstream (`evt_up_i`=0) and reported on the secondary bus sets secondary status bit 24 only when `cfg_sec_per_i` is 1.
- R4: A posted write that is upstream (`evt_up_i`=1) and reported on the primary bus sets primary status bit 24 only when `cfg_pri_per_i` is 1.
- R5: A target-side posted-write event (downstream on the secondary bus, or upstream on the primary bus) drives `serr_n_o` low and sets primary status bit 30 only when all of the following hold: `cfg_serr_en_i`=1, `cfg_pw_serr_dis_i`=0, `cfg_pri_per_i`=1, `cfg_sec_per_i`=1, and `evt_fwd_i`=0.
- R6: An event with `evt_fwd_i`=1 never drives `serr_n_o` low and never sets primary status bit 30.
- R7: Read events (`evt_pw_i`=0) never set bit 24 of either word, never set primary bit 30, and never drive `serr_n_o` low.
- R8: Status bits are sticky. Writing a one to a bit position through a clear port clears that bit. Writing a zero leaves the bit unchanged.
- R9: When a set event and a clear of the same bit fall on the same cycle, the bit ends up set.
- R10: Status and `serr_n_o` change on the first clock edge after the event. `serr_n_o` is low for exactly one clock per qualifying event and is high otherwise.
- R11: Status bit positions other than 31, 30 (primary only) and 24 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid_i | input | 1 | Parity error event strobe, one per cycle |
| evt_pw_i | input | 1 | 1 = posted write, 0 = read |
| evt_up_i | input | 1 | 1 = upstream, 0 = downstream |
| evt_sec_i | input | 1 | 1 = detected on secondary bus, 0 = primary bus |
| evt_fwd_i | input | 1 | 1 = error forwarded from the initiator bus |
| cfg_serr_en_i | input | 1 | System error enable |
| cfg_pri_per_i | input | 1 | Primary parity error response enable |
| cfg_sec_per_i | input | 1 | Secondary parity error response enable |
| cfg_pw_serr_dis_i | input | 1 | Disable system error for posted-write parity |
| pri_clr_we_i | input | 1 | Primary status clear strobe |
| pri_clr_data_i | input | STAT_W | Primary clear mask, ones clear |
| sec_clr_we_i | input | 1 | Secondary status clear strobe |
| sec_clr_data_i | input | STAT_W | Secondary clear mask, ones clear |
| pri_status_o | output | STAT_W | Primary status word |
| sec_status_o | output | STAT_W | Secondary status word |
| serr_n_o | output | 1 | Active-low system error pulse |

## Verification
The main sweep applies every combination of the four event attributes against every combination of the four configuration enables, 256 cases, each starting from cleared status. This separates the event that only marks detection from the one that also records data parity, and both of those from the single target-side, unforwarded, fully enabled case that raises system error. Directed sequences then cover the remaining behaviour:
- Back-to-back qualifying events, which must give two low cycles.
- Clear writes of zeros and of ones.
- A clear that collides with a set on the same cycle.
- Writes to the unused bit positions.

// File: rtl/bridge_perr_pkg.sv
package bridge_perr_pkg;

  typedef struct packed {
    logic valid;
    logic pw;
    logic up;
    logic on_sec;
    logic fwd;
  } perr_evt_t;

  typedef struct packed {
    logic serr_en;
    logic pri_per;
    logic sec_per;
    logic pw_dis;
  } perr_cfg_t;

  typedef struct packed {
    logic pri_det;
    logic sec_det;
    logic pri_dpd;
    logic sec_dpd;
    logic raise;
  } perr_set_t;

endpackage

// File: rtl/bperr_classify.sv
module bperr_classify
  import bridge_perr_pkg::*;
(
  input  perr_evt_t evt,
  input  perr_cfg_t cfg,
  output perr_set_t set_o
);

  logic tgt_side;
  logic all_en;

  always_comb begin
    // target-side report: downstream seen on secondary, or upstream seen on primary
    tgt_side      = evt.on_sec ^ evt.up;
    all_en        = cfg.serr_en & ~cfg.pw_dis & cfg.pri_per & cfg.sec_per;
    set_o.pri_det = evt.valid & ~evt.on_sec;
    set_o.sec_det = evt.valid & evt.on_sec;
    set_o.sec_dpd = evt.valid & evt.pw & ~evt.up & evt.on_sec & cfg.sec_per;
    set_o.pri_dpd = evt.valid & evt.pw & evt.up & ~evt.on_sec & cfg.pri_per;
    set_o.raise   = evt.valid & evt.pw & tgt_side & ~evt.fwd & all_en;
  end

endmodule

// File: rtl/bperr_sticky_bank.sv
module bperr_sticky_bank #(
  parameter int          W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] clr_eff;
  logic [W-1:0] q_d;

  always_comb begin
    clr_eff = clr_we_i ? clr_i : '0;
    // set takes priority over a simultaneous clear
    q_d     = ((q_o & ~clr_eff) | set_i) & MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= q_d;
  end

endmodule

// File: rtl/bperr_serr_drive.sv
module bperr_serr_drive (
  input  logic clk,
  input  logic rst,
  input  logic raise_i,
  output logic serr_n_o
);

  always_ff @(posedge clk) begin
    if (rst) serr_n_o <= 1'b1;
    else     serr_n_o <= ~raise_i;
  end

endmodule

// File: rtl/bridge_perr_report.sv
module bridge_perr_report
  import bridge_perr_pkg::*;
#(
  parameter int STAT_W  = 32,
  parameter int DET_BIT = 31,
  parameter int SSE_BIT = 30,
  parameter int DPD_BIT = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_valid_i,
  input  logic              evt_pw_i,
  input  logic              evt_up_i,
  input  logic              evt_sec_i,
  input  logic              evt_fwd_i,
  input  logic              cfg_serr_en_i,
  input  logic              cfg_pri_per_i,
  input  logic              cfg_sec_per_i,
  input  logic              cfg_pw_serr_dis_i,
  input  logic              pri_clr_we_i,
  input  logic [STAT_W-1:0] pri_clr_data_i,
  input  logic              sec_clr_we_i,
  input  logic [STAT_W-1:0] sec_clr_data_i,
  output logic [STAT_W-1:0] pri_status_o,
  output logic [STAT_W-1:0] sec_status_o,
  output logic              serr_n_o
);

  localparam logic [STAT_W-1:0] ONE      = {{(STAT_W-1){1'b0}}, 1'b1};
  localparam logic [STAT_W-1:0] PRI_MASK = (ONE << DET_BIT) | (ONE << SSE_BIT) | (ONE << DPD_BIT);
  localparam logic [STAT_W-1:0] SEC_MASK = (ONE << DET_BIT) | (ONE << DPD_BIT);

  perr_evt_t         evt;
  perr_cfg_t         cfg;
  perr_set_t         setv;
  logic [STAT_W-1:0] pri_set;
  logic [STAT_W-1:0] sec_set;

  always_comb begin
    evt.valid   = evt_valid_i;
    evt.pw      = evt_pw_i;
    evt.up      = evt_up_i;
    evt.on_sec  = evt_sec_i;
    evt.fwd     = evt_fwd_i;
    cfg.serr_en = cfg_serr_en_i;
    cfg.pri_per = cfg_pri_per_i;
    cfg.sec_per = cfg_sec_per_i;
    cfg.pw_dis  = cfg_pw_serr_dis_i;
  end

  bperr_classify u_classify (
    .evt   (evt),
    .cfg   (cfg),
    .set_o (setv)
  );

  always_comb begin
    pri_set          = '0;
    pri_set[DET_BIT] = setv.pri_det;
    pri_set[SSE_BIT] = setv.raise;
    pri_set[DPD_BIT] = setv.pri_dpd;
    sec_set          = '0;
    sec_set[DET_BIT] = setv.sec_det;
    sec_set[DPD_BIT] = setv.sec_dpd;
  end

  bperr_sticky_bank #(.W(STAT_W), .MASK(PRI_MASK)) u_pri_bank (
    .clk      (clk),
    .rst      (rst),
    .set_i    (pri_set),
    .clr_we_i (pri_clr_we_i),
    .clr_i    (pri_clr_data_i),
    .q_o      (pri_status_o)
  );

  bperr_sticky_bank #(.W(STAT_W), .MASK(SEC_MASK)) u_sec_bank (
    .clk      (clk),
    .rst      (rst),
    .set_i    (sec_set),
    .clr_we_i (sec_clr_we_i),
    .clr_i    (sec_clr_data_i),
    .q_o      (sec_status_o)
  );

  bperr_serr_drive u_serr (
    .clk      (clk),
    .rst      (rst),
    .raise_i  (setv.raise),
    .serr_n_o (serr_n_o)
  );

endmodule

// File: rtl/bridge_perr_report_chk.sv
module bridge_perr_report_chk #(
  parameter int STAT_W  = 32,
  parameter int DET_BIT = 31,
  parameter int SSE_BIT = 30,
  parameter int DPD_BIT = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              evt_valid_i,
  input logic              evt_pw_i,
  input logic              evt_sec_i,
  input logic              evt_fwd_i,
  input logic              cfg_serr_en_i,
  input logic              cfg_pri_per_i,
  input logic              cfg_sec_per_i,
  input logic              cfg_pw_serr_dis_i,
  input logic              pri_clr_we_i,
  input logic [STAT_W-1:0] pri_clr_data_i,
  input logic [STAT_W-1:0] pri_status_o,
  input logic              serr_n_o
);

  AST_SERR_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (rst)
    !serr_n_o |-> $past(cfg_serr_en_i && !cfg_pw_serr_dis_i && cfg_pri_per_i && cfg_sec_per_i)); // R5

  AST_SERR_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
    !serr_n_o |-> pri_status_o[SSE_BIT]); // R5

  AST_FWD_NO_SERR: assert property (@(posedge clk) disable iff (rst)
    !serr_n_o |-> !$past(evt_fwd_i)); // R6

  AST_READ_NO_SERR: assert property (@(posedge clk) disable iff (rst)
    !serr_n_o |-> $past(evt_valid_i && evt_pw_i)); // R7

  AST_DET_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pri_status_o[DET_BIT]) && !$past(pri_clr_we_i && pri_clr_data_i[DET_BIT]))
      |-> pri_status_o[DET_BIT]); // R8

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(evt_valid_i && !evt_sec_i)) |-> pri_status_o[DET_BIT]); // R9

endmodule

bind bridge_perr_report bridge_perr_report_chk #(
  .STAT_W(STAT_W), .DET_BIT(DET_BIT), .SSE_BIT(SSE_BIT), .DPD_BIT(DPD_BIT)
) u_chk (.*);

// File: tb/bridge_perr_report_bench.sv
module bridge_perr_report_bench;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic         ev, epw, eup, esec, efwd;
  logic         c_serr, c_pper, c_sper, c_dis;
  logic         pwe, swe;
  logic [W-1:0] pdat, sdat;
  logic [W-1:0] pstat, sstat;
  logic         serr_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bridge_perr_report u_bridge_perr_report (
    .clk(clk), .rst(rst),
    .evt_valid_i(ev), .evt_pw_i(epw), .evt_up_i(eup), .evt_sec_i(esec), .evt_fwd_i(efwd),
    .cfg_serr_en_i(c_serr), .cfg_pri_per_i(c_pper), .cfg_sec_per_i(c_sper),
    .cfg_pw_serr_dis_i(c_dis),
    .pri_clr_we_i(pwe), .pri_clr_data_i(pdat), .sec_clr_we_i(swe), .sec_clr_data_i(sdat),
    .pri_status_o(pstat), .sec_status_o(sstat), .serr_n_o(serr_n)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ev = 0; epw = 0; eup = 0; esec = 0; efwd = 0;
    pwe = 0; swe = 0; pdat = '0; sdat = '0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    idle_inputs();
    pwe = 1; swe = 1; pdat = '1; sdat = '1;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    c_serr = 0; c_pper = 0; c_sper = 0; c_dis = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 pri reset", pstat, '0);
    check("R1 sec reset", sstat, '0);
    check("R1 serr reset", {31'b0, serr_n}, 32'd1);

    // exhaustive sweep: 4 event attributes x 4 config enables
    for (int i = 0; i < 256; i++) begin
      logic pw, up, sc, fw, se, pp, sp, ds, tgt, rz;
      logic [W-1:0] ep, es;
      {pw, up, sc, fw} = i[7:4];
      {se, pp, sp, ds} = i[3:0];
      tgt = (sc && !up) || (!sc && up);
      rz  = pw && tgt && !fw && se && !ds && pp && sp;
      ep = '0; es = '0;
      ep[31] = !sc;
      es[31] = sc;
      ep[24] = pw && up && !sc && pp;
      es[24] = pw && !up && sc && sp;
      ep[30] = rz;
      clear_all();
      c_serr = se; c_pper = pp; c_sper = sp; c_dis = ds;
      ev = 1; epw = pw; eup = up; esec = sc; efwd = fw;
      @(negedge clk);
      idle_inputs();
      // R2 R3 R4 R5 R6 R7 R10: visible one edge after the event
      check($sformatf("R2/R3/R4/R5/R7 pri case %0d", i), pstat, ep);
      check($sformatf("R2/R3 sec case %0d", i), sstat, es);
      check($sformatf("R5/R6/R7/R10 serr case %0d", i), {31'b0, serr_n}, {31'b0, !rz});
      @(negedge clk);
      check($sformatf("R10 serr release case %0d", i), {31'b0, serr_n}, 32'd1);
      check($sformatf("R8 hold case %0d", i), pstat, ep);
    end

    // R10: back-to-back qualifying events give two low cycles
    clear_all();
    c_serr = 1; c_pper = 1; c_sper = 1; c_dis = 0;
    ev = 1; epw = 1; eup = 0; esec = 1; efwd = 0;
    @(negedge clk);
    check("R10 b2b first", {31'b0, serr_n}, 32'd0);
    eup = 1; esec = 0;
    @(negedge clk);
    idle_inputs();
    check("R10 b2b second", {31'b0, serr_n}, 32'd0);
    @(negedge clk);
    check("R10 b2b release", {31'b0, serr_n}, 32'd1);
    check("R5 pri after b2b", pstat, 32'hC100_0000);
    check("R3 sec after b2b", sstat, 32'h8100_0000);

    // R8: writing zeros changes nothing, ones clear selected bits
    pwe = 1; pdat = '0; swe = 1; sdat = '0;
    @(negedge clk);
    idle_inputs();
    check("R8 zero write pri", pstat, 32'hC100_0000);
    check("R8 zero write sec", sstat, 32'h8100_0000);
    pwe = 1; pdat = 32'h4000_0000;
    @(negedge clk);
    idle_inputs();
    check("R8 clear bit30 only", pstat, 32'h8100_0000);
    swe = 1; sdat = 32'h8000_0000;
    @(negedge clk);
    idle_inputs();
    check("R8 clear sec bit31", sstat, 32'h0100_0000);

    // R9: set and clear on the same cycle, set wins
    clear_all();
    c_pper = 0; c_sper = 0;
    ev = 1; epw = 0; esec = 0;
    pwe = 1; pdat = '1;
    @(negedge clk);
    idle_inputs();
    check("R9 set wins pri", pstat, 32'h8000_0000);
    ev = 1; esec = 1;
    swe = 1; sdat = '1;
    @(negedge clk);
    idle_inputs();
    check("R9 set wins sec", sstat, 32'h8000_0000);

    // R11: unused positions stay zero
    clear_all();
    c_serr = 1; c_pper = 1; c_sper = 1;
    ev = 1; epw = 1; eup = 1; esec = 0;
    @(negedge clk);
    ev = 1; epw = 1; eup = 0; esec = 1;
    @(negedge clk);
    idle_inputs();
    check("R11 pri mask", pstat & ~32'hC100_0000, '0);
    check("R11 sec mask", sstat & ~32'h8100_0000, '0);

    // R1: reset clears sticky state
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1 pri after reset", pstat, '0);
    check("R1 sec after reset", sstat, '0);
    check("R1 serr after reset", {31'b0, serr_n}, 32'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule